// File: doc/BRIEF.md
# Strobed-Command Timer Bank

The block holds several independent up-counting timers behind one small 32-bit register bus. Every channel has its own 64-byte register window and its own interrupt line. Software starts, stops and clears a channel by writing to a dedicated command address, and the data written there does not matter. It selects continuous or one-shot operation, sets a limit (terminal count), enables the interrupt and acknowledges events through ordinary registers. It reads a coded status word and the live count back through the same bus.

Counting is paced from outside. Each channel has a tick-enable input, and its count advances only on bus-clock cycles where that tick is high and the channel is running. In continuous mode a channel with the limit at all ones is a free-running time base. With a smaller limit it gives periodic events. In one-shot mode it produces a single event and then parks. A single control register placed after the last window drives a clock-request output.

Top module: `tick_timer_bank`

## Requirements
- R1: After the synchronous reset, every count is 0 and every limit is 0xFFFFFFFF. Every channel is idle in continuous mode, with its interrupt disabled and nothing pending. `irq` and `clk_req` are low and `bus_rdata` is 0.
- R2: Channel n occupies byte addresses 0x40*n to 0x40*n+0x3F. Its registers sit at these offsets: status +0x10 and count +0x14 (read-only), limit +0x18 (read/write), and reset +0x00, start +0x04, stop +0x08, mode +0x0C, interrupt enable +0x1C and acknowledge +0x20 (write-only). A read strobe returns data on `bus_rdata` in the following cycle. Reads of write-only or unmapped addresses return 0.
- R3: A write to the reset, start or stop address performs that command whatever data value is written.
- R4: While a channel is running, its count rises by one on each cycle where its tick input is high. Otherwise the count holds.
- R5: In continuous mode (mode bit 0 = 0), a tick that arrives while the count equals the limit sets the pending flag and returns the count to 0, and the channel keeps running. With the limit at 0xFFFFFFFF the count wraps freely.
- R6: In one-shot mode (mode bit 0 = 1), a tick that arrives while the count equals the limit sets the pending flag. The count stays at the limit, and the channel goes idle with its enabled flag clear until the next start command.
- R7: The status word holds the run state in bits [3:0] (1 = idle, 2 = running). The other bits are: bit 4 enabled, bit 5 one-shot, bit 6 interrupt enabled, bit 7 pending. Bits [31:8] read 0.
- R8: A write to the acknowledge address with data bit 7 set clears the pending flag. Without bit 7 the write has no effect. An expiry in the same cycle as an acknowledge leaves the flag set.
- R9: A reset command zeroes the count, clears the pending flag and idles the channel, but keeps the limit, mode and interrupt enable. A stop command idles the channel and freezes the count without clearing it.
- R10: The pending flag is set on expiry even when the interrupt is disabled. `irq[n]` is high exactly when channel n is pending and its interrupt-enable bit (bit 0 of +0x1C) is 1.
- R11: The control register at 0x40*NCH (0x100 by default) stores data bit 0. That bit drives `clk_req` and reads back in bit 0.
- R12: Commands, writes and ticks aimed at one channel leave every other channel's count, status and interrupt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one cycle per access |
| bus_re | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | AW (9) | Byte address, word aligned |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, valid the cycle after `bus_re` |
| tick_en | input | NCH (4) | Per-channel count-enable pulses |
| irq | output | NCH (4) | Per-channel interrupt, pending AND enabled |
| clk_req | output | 1 | Clock-request output from the control register |

## Verification
The assertions assume that writes and reads arrive as single-cycle strobes at word-aligned addresses, and that a command and a register write never hit the same channel in the same cycle, since the bus carries one access per cycle. They also assume the tick inputs are already synchronous to `clk`. The stimulus drives all inputs on the falling edge. It issues at most one strobe per cycle and draws addresses only from the defined offsets of each window. It keeps random limits small so that periodic and one-shot expiries, acknowledges racing expiries, and commands landing on tick cycles all occur many times.

// File: rtl/tmrbank_pkg.sv
package tmrbank_pkg;
  localparam int WIN_BYTES = 64;
  localparam logic [5:0] OFS_RESET = 6'h00;
  localparam logic [5:0] OFS_START = 6'h04;
  localparam logic [5:0] OFS_STOP  = 6'h08;
  localparam logic [5:0] OFS_MODE  = 6'h0C;
  localparam logic [5:0] OFS_STAT  = 6'h10;
  localparam logic [5:0] OFS_COUNT = 6'h14;
  localparam logic [5:0] OFS_LIMIT = 6'h18;
  localparam logic [5:0] OFS_IEN   = 6'h1C;
  localparam logic [5:0] OFS_ACK   = 6'h20;
  localparam logic [3:0] RUN_IDLE  = 4'd1;
  localparam logic [3:0] RUN_BUSY  = 4'd2;

  // one strobe per write-side register of a channel window
  typedef struct packed {
    logic reset;
    logic start;
    logic stop;
    logic mode;
    logic limit;
    logic ien;
    logic ack;
  } chan_cmd_t;
endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
  import tmrbank_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 9
) (
  input  logic                  we_i,
  input  logic [AW-1:0]         addr_i,
  output chan_cmd_t [NCH-1:0]   cmd_o,
  output logic                  ctl_wr_o
);
  localparam int CTL_ADDR = NCH * WIN_BYTES;
  localparam int CHW      = (NCH > 1) ? $clog2(NCH) : 1;

  logic            in_win;
  logic [5:0]      ofs;
  logic [CHW-1:0]  sel;

  assign in_win   = (int'(addr_i) < CTL_ADDR);
  assign ofs      = addr_i[5:0];
  assign sel      = CHW'(addr_i >> 6);
  assign ctl_wr_o = we_i && (int'(addr_i) == CTL_ADDR);

  for (genvar c = 0; c < NCH; c++) begin : g_dec
    logic hit;
    assign hit = we_i && in_win && (int'(sel) == c);
    assign cmd_o[c].reset = hit && (ofs == OFS_RESET);
    assign cmd_o[c].start = hit && (ofs == OFS_START);
    assign cmd_o[c].stop  = hit && (ofs == OFS_STOP);
    assign cmd_o[c].mode  = hit && (ofs == OFS_MODE);
    assign cmd_o[c].limit = hit && (ofs == OFS_LIMIT);
    assign cmd_o[c].ien   = hit && (ofs == OFS_IEN);
    assign cmd_o[c].ack   = hit && (ofs == OFS_ACK);
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmrbank_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  chan_cmd_t     cmd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] limit_o,
  output logic [7:0]    stat_o,
  output logic          irq_o
);
  logic [DW-1:0] cnt_q, cnt_n, limit_q, limit_n;
  logic act_q, act_n, osh_q, osh_n, ien_q, ien_n, pend_q, pend_n, irq_q;
  logic hit_limit;

  assign hit_limit = act_q && tick_i && (cnt_q == limit_q);

  always_comb begin
    cnt_n   = cnt_q;
    limit_n = limit_q;
    act_n   = act_q;
    osh_n   = osh_q;
    ien_n   = ien_q;
    pend_n  = pend_q;
    if (cmd_i.ack && wdata_i[7]) pend_n = 1'b0;
    if (hit_limit) begin
      pend_n = 1'b1;
      if (osh_q) act_n = 1'b0;
      else       cnt_n = '0;
    end else if (act_q && tick_i) begin
      cnt_n = cnt_q + 1'b1;
    end
    if (cmd_i.start) act_n = 1'b1;
    if (cmd_i.stop)  act_n = 1'b0;
    if (cmd_i.reset) begin
      cnt_n  = '0;
      pend_n = 1'b0;
      act_n  = 1'b0;
    end
    if (cmd_i.mode)  osh_n   = wdata_i[0];
    if (cmd_i.limit) limit_n = wdata_i;
    if (cmd_i.ien)   ien_n   = wdata_i[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      limit_q <= '1;
      act_q   <= 1'b0;
      osh_q   <= 1'b0;
      ien_q   <= 1'b0;
      pend_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      limit_q <= limit_n;
      act_q   <= act_n;
      osh_q   <= osh_n;
      ien_q   <= ien_n;
      pend_q  <= pend_n;
      irq_q   <= pend_n && ien_n;
    end
  end

  assign cnt_o   = cnt_q;
  assign limit_o = limit_q;
  assign irq_o   = irq_q;
  assign stat_o  = {pend_q, ien_q, osh_q, act_q, (act_q ? RUN_BUSY : RUN_IDLE)};

  // R9
  reset_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_i.reset |=> (cnt_q == '0) && !pend_q && !act_q);
  // R6
  oneshot_park_chk: assert property (@(posedge clk) disable iff (rst)
    (act_q && osh_q && tick_i && (cnt_q == limit_q) && (cmd_i == '0))
      |=> !act_q && pend_q && $stable(cnt_q));
  // R5
  periodic_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (act_q && !osh_q && tick_i && (cnt_q == limit_q) && (cmd_i == '0))
      |=> act_q && pend_q && (cnt_q == '0));
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!act_q && !cmd_i.reset) |=> $stable(cnt_q));
  // R8
  pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pend_q) |-> $past(cmd_i.reset || (cmd_i.ack && wdata_i[7])));
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tmrbank_pkg::*;
#(
  parameter  int NCH = 4,
  parameter  int DW  = 32,
  localparam int AW  = $clog2(NCH * WIN_BYTES) + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_we,
  input  logic           bus_re,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic [NCH-1:0] tick_en,
  output logic [NCH-1:0] irq,
  output logic           clk_req
);
  localparam int CTL_ADDR = NCH * WIN_BYTES;
  localparam int CHW      = (NCH > 1) ? $clog2(NCH) : 1;

  chan_cmd_t [NCH-1:0] cmd;
  logic                ctl_wr;
  logic                creq_q;
  logic [DW-1:0]       cnt_a   [NCH];
  logic [DW-1:0]       limit_a [NCH];
  logic [7:0]          stat_a  [NCH];
  logic [DW-1:0]       rd_n, rdata_q;
  logic [CHW-1:0]      rsel;

  tmr_cmd_decode #(.NCH(NCH), .AW(AW)) dec_i (
    .we_i    (bus_we),
    .addr_i  (bus_addr),
    .cmd_o   (cmd),
    .ctl_wr_o(ctl_wr)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tmr_channel #(.DW(DW)) ch_i (
      .clk    (clk),
      .rst    (rst),
      .tick_i (tick_en[c]),
      .cmd_i  (cmd[c]),
      .wdata_i(bus_wdata),
      .cnt_o  (cnt_a[c]),
      .limit_o(limit_a[c]),
      .stat_o (stat_a[c]),
      .irq_o  (irq[c])
    );
  end

  assign rsel = CHW'(bus_addr >> 6);

  always_comb begin
    rd_n = '0;
    if (int'(bus_addr) == CTL_ADDR) begin
      rd_n[0] = creq_q;
    end else if (int'(bus_addr) < CTL_ADDR) begin
      case (bus_addr[5:0])
        OFS_STAT:  rd_n = DW'(stat_a[rsel]);
        OFS_COUNT: rd_n = cnt_a[rsel];
        OFS_LIMIT: rd_n = limit_a[rsel];
        default:   rd_n = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      creq_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (ctl_wr) creq_q  <= bus_wdata[0];
      if (bus_re) rdata_q <= rd_n;
    end
  end

  assign clk_req   = creq_q;
  assign bus_rdata = rdata_q;
endmodule

// File: tb/tick_timer_bank_tb.sv
module tick_timer_bank_tb_top;
  localparam int NCH = 4;
  localparam int AW  = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [AW-1:0]  bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic [NCH-1:0] tick_en = '0;
  logic [NCH-1:0] irq;
  logic           clk_req;

  int vectors = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tick_timer_bank dut_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .irq(irq), .clk_req(clk_req)
  );

  // behavioural reference model
  logic [31:0] m_cnt [NCH];
  logic [31:0] m_lim [NCH];
  bit m_act [NCH], m_osh [NCH], m_ien [NCH], m_pnd [NCH];
  bit [NCH-1:0] m_irq;
  bit m_creq;
  logic [31:0] m_rd;

  always @(posedge clk) begin : model
    int a, ch, off;
    bit exp_hit;
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        m_cnt[i] = 0; m_lim[i] = 32'hFFFF_FFFF;
        m_act[i] = 0; m_osh[i] = 0; m_ien[i] = 0; m_pnd[i] = 0;
      end
      m_irq = '0; m_creq = 0; m_rd = 0;
    end else begin
      a = int'(bus_addr); ch = a / 64; off = a % 64;
      if (bus_re) begin
        m_rd = 0;
        if (a == NCH * 64) m_rd = {31'd0, m_creq};
        else if (a < NCH * 64) begin
          if (off == 16) m_rd = {24'd0, m_pnd[ch], m_ien[ch], m_osh[ch], m_act[ch],
                                 (m_act[ch] ? 4'd2 : 4'd1)};
          else if (off == 20) m_rd = m_cnt[ch];
          else if (off == 24) m_rd = m_lim[ch];
        end
      end
      for (int i = 0; i < NCH; i++) begin
        bit w;
        w = bus_we && (a < NCH * 64) && (ch == i);
        if (w && off == 32 && bus_wdata[7]) m_pnd[i] = 0;
        exp_hit = m_act[i] && tick_en[i] && (m_cnt[i] == m_lim[i]);
        if (exp_hit) begin
          m_pnd[i] = 1;
          if (m_osh[i]) m_act[i] = 0; else m_cnt[i] = 0;
        end else if (m_act[i] && tick_en[i]) m_cnt[i] = m_cnt[i] + 1;
        if (w && off == 4) m_act[i] = 1;
        if (w && off == 8) m_act[i] = 0;
        if (w && off == 0) begin m_cnt[i] = 0; m_pnd[i] = 0; m_act[i] = 0; end
        if (w && off == 12) m_osh[i] = bus_wdata[0];
        if (w && off == 24) m_lim[i] = bus_wdata;
        if (w && off == 28) m_ien[i] = bus_wdata[0];
        m_irq[i] = m_pnd[i] && m_ien[i];
      end
      if (bus_we && a == NCH * 64) m_creq = bus_wdata[0];
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      vectors++;
      if (irq !== m_irq) begin
        fails++; $display("FAIL R10 irq got %b exp %b", irq, m_irq);
      end
      if (clk_req !== m_creq) begin
        fails++; $display("FAIL R11 clk_req got %b exp %b", clk_req, m_creq);
      end
      if (bus_rdata !== m_rd) begin
        fails++; $display("FAIL R2 rdata got %h exp %h", bus_rdata, m_rd);
      end
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++; $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(int addr, logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = AW'(addr); bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(int addr, output logic [31:0] v);
    @(negedge clk); bus_re = 1; bus_addr = AW'(addr);
    @(negedge clk); bus_re = 0; v = bus_rdata;
  endtask

  task automatic ticks(logic [NCH-1:0] mask, int n);
    @(negedge clk); tick_en = mask;
    repeat (n) @(negedge clk);
    tick_en = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : stim
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {28'd0, irq}, 0);
    check("R1 clk_req", {31'd0, clk_req}, 0);
    rd(16'h10, v);  check("R1 status ch0", v, 32'h01);
    rd(16'h14, v);  check("R1 count ch0", v, 0);
    rd(16'h18, v);  check("R1 limit ch0", v, 32'hFFFF_FFFF);
    // ch0 continuous, limit 5
    wr(16'h18, 5); wr(16'h0C, 0); wr(16'h1C, 1);
    wr(16'h04, 32'hDEAD_BEEF);                       // R3 start ignores data
    rd(16'h10, v);  check("R7 status running", v, 32'h52);
    ticks(4'b0001, 3);
    rd(16'h14, v);  check("R4 count after 3 ticks", v, 3);
    rd(16'h14, v);  check("R4 count holds w/o tick", v, 3);
    ticks(4'b0001, 3);
    rd(16'h14, v);  check("R5 count restarts", v, 0);
    rd(16'h10, v);  check("R5 pending running", v, 32'hD2);
    check("R10 irq0 raised", {31'd0, irq[0]}, 1);
    wr(16'h20, 32'h7F);
    rd(16'h10, v);  check("R8 ack w/o bit7 ignored", v, 32'hD2);
    wr(16'h20, 32'h80);
    rd(16'h10, v);  check("R8 ack clears", v, 32'h52);
    check("R10 irq0 low", {31'd0, irq[0]}, 0);
    // ch1 one-shot, limit 2, interrupt disabled
    wr(16'h58, 2); wr(16'h4C, 1); wr(16'h44, 0);
    ticks(4'b0010, 5);
    rd(16'h54, v);  check("R6 count parks at limit", v, 2);
    rd(16'h50, v);  check("R6 idle pending oneshot", v, 32'hA1);
    check("R10 no irq when disabled", {31'd0, irq[1]}, 0);
    wr(16'h40, 32'h1234_5678);                       // R3 reset ignores data
    rd(16'h54, v);  check("R9 reset zeroes count", v, 0);
    rd(16'h50, v);  check("R9 reset keeps mode", v, 32'h21);
    rd(16'h58, v);  check("R9 reset keeps limit", v, 2);
    // ch2 stop freezes
    wr(16'h84, 0);
    ticks(4'b0100, 4);
    wr(16'h88, 32'hFFFF_FFFF);                       // R3 stop ignores data
    rd(16'h90, v);  check("R9 stop idles", v, 32'h01);
    ticks(4'b0100, 3);
    rd(16'h94, v);  check("R9 stop freezes count", v, 4);
    // R12 untouched channel
    rd(16'hD0, v);  check("R12 ch3 status", v, 32'h01);
    rd(16'hD4, v);  check("R12 ch3 count", v, 0);
    rd(16'h14, v);  check("R12 ch0 count untouched", v, 0);
    // R11 control register
    wr(16'h100, 32'hFFFF_FFFF);
    check("R11 clk_req set", {31'd0, clk_req}, 1);
    rd(16'h100, v); check("R11 readback", v, 1);
    wr(16'h100, 32'h2);
    check("R11 clk_req clear", {31'd0, clk_req}, 0);
    // R2 write-only and unused offsets read 0
    rd(16'h0C, v);  check("R2 write-only reads 0", v, 0);
    rd(16'h3C, v);  check("R2 unused reads 0", v, 0);
    // random phase, compared to the model every clock
    for (int i = 0; i < 6000; i++) begin
      int kind, ch, sel;
      @(negedge clk);
      bus_we = 0; bus_re = 0;
      tick_en = NCH'($urandom);
      kind = $urandom_range(0, 9);
      ch = $urandom_range(0, NCH - 1);
      sel = $urandom_range(0, 9);
      if (kind < 4) begin
        bus_we = 1;
        case (sel)
          0, 1: begin bus_addr = AW'(ch * 64 + 24); bus_wdata = $urandom_range(0, 12); end
          2: begin bus_addr = AW'(ch * 64 + 0);  bus_wdata = $urandom; end
          3, 4: begin bus_addr = AW'(ch * 64 + 4); bus_wdata = $urandom; end
          5: begin bus_addr = AW'(ch * 64 + 8);  bus_wdata = $urandom; end
          6: begin bus_addr = AW'(ch * 64 + 12); bus_wdata = $urandom; end
          7: begin bus_addr = AW'(ch * 64 + 28); bus_wdata = $urandom; end
          8: begin bus_addr = AW'(ch * 64 + 32); bus_wdata = $urandom; end
          default: begin bus_addr = AW'(NCH * 64); bus_wdata = $urandom; end
        endcase
      end else if (kind < 8) begin
        bus_re = 1;
        bus_addr = (sel == 9) ? AW'(NCH * 64) : AW'(ch * 64 + 4 * sel);
      end
    end
    @(negedge clk); bus_we = 0; bus_re = 0; tick_en = '0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule